// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Line-Break Detection

This block turns an asynchronous serial bit stream into parallel characters. It runs entirely on the receive clock. A programmable rate factor of 1, 16 or 64 receive-clock cycles per bit sets the bit rate. At factors 16 and 64 the line is sampled in the middle of each bit. Each character has a start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit and one stop bit.

A finished character is placed in a holding register, and a ready flag tells the host a character is waiting. Parity, framing and overrun problems set sticky error flags, and only an error-clear strobe from the control sequencer resets them. A line held low through a whole frame, stop bit included, raises a break-detect output. That output stays high until the line returns to the mark (high) level.

The mode fields, the receive enable and the error-clear strobe come from a control sequencer. The read strobe comes from the host's data-register read.

Top module: `async_char_receiver`

## Requirements
- R1: After reset, rx_ready, err_parity, err_frame, err_overrun and brk_det are 0 and rd_data is 0.
- R2: One bit lasts F receive-clock cycles, where F is set by cfg_rate: 2'b10 gives 16, 2'b11 gives 64, and 2'b00 or 2'b01 gives 1. Characters are received correctly at all three factors.
- R3: cfg_bits selects the character length: 2'b00 is 5 bits, 2'b01 is 6, 2'b10 is 7 and 2'b11 is 8. The first data bit received lands in rd_data[0], and rd_data bits above the character length read 0.
- R4: At factors 16 and 64, a falling edge on the line starts a character only if the line is still low half a bit time later. Otherwise the receiver goes back to waiting and delivers nothing.
- R5: When cfg_par_en is 1, a parity bit follows the data. With cfg_par_even = 1, even parity is expected (the parity bit equals the XOR of the data bits); with cfg_par_even = 0, odd parity is expected. A mismatch sets err_parity.
- R6: A stop bit sampled low sets err_frame.
- R7: Each character received while rx_en is 1 is written to rd_data and sets rx_ready. A one-cycle rd_strobe pulse clears rx_ready.
- R8: If rx_ready is still 1 when the next character completes, err_overrun is set, and rd_data holds the newer character.
- R9: err_parity, err_frame and err_overrun stay set through later good characters. A one-cycle err_clr pulse clears all three.
- R10: brk_det rises when a frame has all data bits, the parity bit (if enabled) and the stop bit low. It falls within 4 cycles after the line returns high.
- R11: While rx_en is 0, a completed character leaves rd_data, rx_ready and the three error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_rate | input | 2 | Rate factor: 10 = 16, 11 = 64, otherwise 1 |
| cfg_bits | input | 2 | Character length minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rx_en | input | 1 | Receive enable |
| err_clr | input | 1 | Error-flag clear strobe |
| rd_strobe | input | 1 | Host read of the data register |
| rd_data | output | 8 | Received character, right-justified |
| rx_ready | output | 1 | Character waiting |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Line break detected |

## Verification
The line passes through a two-stage synchronizer, so the stop sample falls 2 cycles after the middle of the stop bit (at factor 1, after the bit itself). rd_data, rx_ready and the error flags update one cycle after that sample. The bench therefore drives a full stop-bit time and then waits 4 more cycles before it samples the results, and it samples on the falling edge. rd_strobe and err_clr take effect at the next rising edge, and the bench checks them one cycle later. brk_det falls 3 cycles after the line goes high, and the bench checks it 4 cycles after the release.

// File: rtl/rx_pkg.sv
// Shared types and mode encodings for the asynchronous character receiver.
package rx_pkg;
    localparam int DATA_W     = 8;
    localparam int MAX_FACTOR = 64;
    localparam int CNT_W      = $clog2(MAX_FACTOR);
    localparam int IDX_W      = $clog2(DATA_W);

    localparam logic [1:0] RATE_X16 = 2'b10;
    localparam logic [1:0] RATE_X64 = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
    } rx_state_e;

    // Per-character result handed from the framer to the holding stage.
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_char_t;
endpackage

// File: rtl/rx_line_sync.sv
// Synchronizer for the asynchronous serial input.
// Assumes the line idles high, so every stage resets to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
    end

    assign line_s = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
// Bit-timing and framing state machine.
// Detects a start bit, confirms it at mid-bit, samples the data bits, the optional
// parity bit and the stop bit, and emits a one-cycle done pulse with the result.
// Assumes the mode fields stay stable while a frame is in progress.
module rx_framer
    import rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_s,
    input  logic [1:0] cfg_rate,
    input  logic [1:0] cfg_bits,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    output logic       done,
    output rx_char_t   result
);
    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sr;
    logic              pbit;

    logic [CNT_W-1:0]  full_m1;
    logic [CNT_W-1:0]  half_m1;
    logic              rate_x1;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] aligned;
    logic              par_exp;

    // Derive the bit-timing reload values from the rate field.
    always_comb begin
        rate_x1 = 1'b0;
        full_m1 = '0;
        half_m1 = '0;
        case (cfg_rate)
            RATE_X16: begin
                full_m1 = CNT_W'(15);
                half_m1 = CNT_W'(7);
            end
            RATE_X64: begin
                full_m1 = CNT_W'(63);
                half_m1 = CNT_W'(31);
            end
            default: rate_x1 = 1'b1;
        endcase
    end

    // Right-justify the character and compute the expected parity bit.
    always_comb begin
        last_idx = IDX_W'(cfg_bits) + IDX_W'(DATA_W - 4);
        aligned  = sr >> (IDX_W'(DATA_W - 1) - last_idx);
        par_exp  = cfg_par_even ? (^aligned) : ~(^aligned);
    end

    // Frame state, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            idx    <= '0;
            sr     <= '0;
            pbit   <= 1'b0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (!line_s) begin
                        if (rate_x1) begin
                            state <= ST_DATA;
                            cnt   <= '0;
                        end else begin
                            state <= ST_START;
                            cnt   <= half_m1;
                        end
                    end
                end
                ST_START: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (!line_s) begin
                        state <= ST_DATA;
                        cnt   <= full_m1;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        cnt <= full_m1;
                        sr  <= {line_s, sr[DATA_W-1:1]};
                        idx <= idx + 1'b1;
                        if (idx == last_idx)
                            state <= cfg_par_en ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        cnt   <= full_m1;
                        pbit  <= line_s;
                        state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        done        <= 1'b1;
                        result.data <= aligned;
                        result.perr <= cfg_par_en && (pbit != par_exp);
                        result.ferr <= !line_s;
                        result.brk  <= !line_s && (aligned == '0) &&
                                       (!cfg_par_en || !pbit);
                        state       <= line_s ? ST_IDLE : ST_WAITHI;
                    end
                end
                ST_WAITHI: begin
                    if (line_s) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_holding.sv
// Holding register, ready flag, sticky error flags and break output.
// A character is accepted only while rx_en is high. A newer character overwrites
// an unread one and flags an overrun. When a set and an err_clr meet in one cycle,
// the set wins.
module rx_holding
    import rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_s,
    input  logic              done,
    input  rx_char_t          result,
    input  logic              rx_en,
    input  logic              err_clr,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              brk_det
);
    logic accept;
    assign accept = done && rx_en;

    // Data register and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rx_ready <= 1'b0;
        end else if (accept) begin
            rd_data  <= result.data;
            rx_ready <= 1'b1;
        end else if (rd_strobe) begin
            rx_ready <= 1'b0;
        end
    end

    // Sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (accept && result.perr)     err_parity <= 1'b1;
            else if (err_clr)              err_parity <= 1'b0;
            if (accept && result.ferr)     err_frame <= 1'b1;
            else if (err_clr)              err_frame <= 1'b0;
            if (accept && rx_ready && !rd_strobe) err_overrun <= 1'b1;
            else if (err_clr)              err_overrun <= 1'b0;
        end
    end

    // Break output: set by an all-low frame, cleared when the line is high.
    always_ff @(posedge clk) begin
        if (!rst_n)                     brk_det <= 1'b0;
        else if (line_s)                brk_det <= 1'b0;
        else if (done && result.brk)    brk_det <= 1'b1;
    end
endmodule

// File: rtl/async_char_receiver.sv
// Top level of the asynchronous character receiver.
// Chains the line synchronizer, the framer and the holding stage. It runs on the
// receive clock only.
module async_char_receiver
    import rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic [1:0]        cfg_rate,
    input  logic [1:0]        cfg_bits,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              rx_en,
    input  logic              err_clr,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              brk_det
);
    logic     line_s;
    logic     char_done;
    rx_char_t char_res;

    rx_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(rx_line), .line_s(line_s)
    );

    rx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .line_s(line_s),
        .cfg_rate(cfg_rate), .cfg_bits(cfg_bits),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .done(char_done), .result(char_res)
    );

    rx_holding u_hold (
        .clk(clk), .rst_n(rst_n), .line_s(line_s),
        .done(char_done), .result(char_res),
        .rx_en(rx_en), .err_clr(err_clr), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .brk_det(brk_det)
    );
endmodule

// File: rtl/async_char_receiver_chk.sv
// Property checker for the receiver's holding and flag behaviour.
// Observes the top-level ports plus the synchronized line and the done pulse.
module async_char_receiver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       err_clr,
    input logic       rd_strobe,
    input logic [7:0] rd_data,
    input logic       rx_ready,
    input logic       err_parity,
    input logic       err_frame,
    input logic       err_overrun,
    input logic       brk_det,
    input logic       line_s,
    input logic       char_done
);
    // R7
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !char_done) |=> !rx_ready);
    // R9
    parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity && !err_clr) |=> err_parity);
    // R9
    frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame && !err_clr) |=> err_frame);
    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !char_done) |=> (!err_parity && !err_frame && !err_overrun));
    // R8
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(rx_ready));
    // R10
    break_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_s |=> !brk_det);
    // R11
    disabled_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> $stable(rd_data));
    // R11
    disabled_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rx_ready) |=> !rx_ready);
endmodule

bind async_char_receiver async_char_receiver_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .err_clr(err_clr),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_ready(rx_ready),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .brk_det(brk_det), .line_s(line_s), .char_done(char_done)
);

// File: tb/async_char_receiver_bench.sv
module async_char_receiver_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_rate = 2'b10;
    logic [1:0] cfg_bits = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b1;
    logic       rx_en = 1'b1;
    logic       err_clr = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       rx_ready, err_parity, err_frame, err_overrun, brk_det;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_char_receiver u_async_char_receiver (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cfg_rate(cfg_rate),
        .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .rx_en(rx_en), .err_clr(err_clr), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rx_ready(rx_ready), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun), .brk_det(brk_det)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    function automatic int factor_of(input logic [1:0] r);
        return (r == 2'b10) ? 16 : (r == 2'b11) ? 64 : 1;
    endfunction

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        rx_line = b;
        wait_clk(factor_of(cfg_rate));
    endtask

    // Send one frame; par_flip inverts the parity bit, stop_val sets the stop bit.
    task automatic send_frame(input logic [7:0] ch, input bit par_flip, input logic stop_val);
        int  n = 5 + int'(cfg_bits);
        logic p = 1'b0;
        for (int i = 0; i < n; i++) p ^= ch[i];
        if (!cfg_par_even) p = ~p;
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(ch[i]);
        if (cfg_par_en) drive_bit(p ^ par_flip);
        drive_bit(stop_val);
        rx_line = 1'b1;
        wait_clk(4);
    endtask

    task automatic pulse_read();
        rd_strobe = 1'b1; wait_clk(1); rd_strobe = 1'b0; wait_clk(1);
    endtask

    task automatic pulse_clear();
        err_clr = 1'b1; wait_clk(1); err_clr = 1'b0; wait_clk(1);
    endtask

    task automatic t_reset();
        check_eq("R1 rx_ready", rx_ready, 0);
        check_eq("R1 flags", {err_parity, err_frame, err_overrun}, 0);
        check_eq("R1 brk_det", brk_det, 0);
        check_eq("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_basic_x16();
        cfg_rate = 2'b10; cfg_bits = 2'b11; cfg_par_en = 0;
        send_frame(8'hA5, 0, 1'b1);
        check_eq("R2 x16 data", rd_data, 8'hA5);
        check_eq("R7 ready set", rx_ready, 1);
        check_eq("R6 no frame err", err_frame, 0);
        pulse_read();
        check_eq("R7 ready cleared by read", rx_ready, 0);
    endtask

    task automatic t_short_char();
        cfg_bits = 2'b00;
        send_frame(8'hF5, 0, 1'b1);
        check_eq("R3 5-bit right-justified", rd_data, 8'h15);
        pulse_read();
        cfg_bits = 2'b01; cfg_rate = 2'b00;
        send_frame(8'h2B, 0, 1'b1);
        check_eq("R2 x1 6-bit data", rd_data, 8'h2B);
        check_eq("R2 x1 ready", rx_ready, 1);
        pulse_read();
    endtask

    task automatic t_parity_x64();
        cfg_rate = 2'b11; cfg_bits = 2'b10; cfg_par_en = 1; cfg_par_even = 1;
        send_frame(8'h5A, 0, 1'b1);
        check_eq("R2 x64 7-bit data", rd_data, 8'h5A);
        check_eq("R5 good even parity", err_parity, 0);
        pulse_read();
    endtask

    task automatic t_parity_error();
        cfg_rate = 2'b10; cfg_bits = 2'b11; cfg_par_en = 1; cfg_par_even = 0;
        send_frame(8'h3C, 1, 1'b1);
        check_eq("R5 odd parity mismatch", err_parity, 1);
        pulse_read();
        send_frame(8'h81, 0, 1'b1);
        check_eq("R9 parity flag sticky", err_parity, 1);
        check_eq("R9 later char data", rd_data, 8'h81);
        pulse_read();
        pulse_clear();
        check_eq("R9 clear parity", err_parity, 0);
        cfg_par_en = 0;
    endtask

    task automatic t_framing();
        send_frame(8'h66, 0, 1'b0);
        wait_clk(2);
        check_eq("R6 frame error", err_frame, 1);
        check_eq("R10 no break for nonzero data", brk_det, 0);
        pulse_read();
        pulse_clear();
        check_eq("R9 clear frame", err_frame, 0);
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 0, 1'b1);
        check_eq("R8 no overrun yet", err_overrun, 0);
        send_frame(8'h22, 0, 1'b1);
        check_eq("R8 overrun flagged", err_overrun, 1);
        check_eq("R8 newer data kept", rd_data, 8'h22);
        pulse_read();
        pulse_clear();
        check_eq("R9 clear overrun", err_overrun, 0);
    endtask

    task automatic t_glitch();
        rx_line = 1'b0; wait_clk(3); rx_line = 1'b1; wait_clk(40);
        check_eq("R4 glitch rejected", rx_ready, 0);
        check_eq("R4 data unchanged", rd_data, 8'h22);
        send_frame(8'h47, 0, 1'b1);
        check_eq("R4 next char ok", rd_data, 8'h47);
        pulse_read();
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        send_frame(8'h0F, 1, 1'b0);
        wait_clk(2);
        check_eq("R11 ready stays low", rx_ready, 0);
        check_eq("R11 data unchanged", rd_data, 8'h47);
        check_eq("R11 flags unchanged", {err_parity, err_frame, err_overrun}, 0);
        rx_en = 1'b1;
    endtask

    task automatic t_break();
        rx_line = 1'b0;
        wait_clk(16 * 11);
        check_eq("R10 break detected", brk_det, 1);
        check_eq("R6 break frame error", err_frame, 1);
        check_eq("R10 break data zero", rd_data, 0);
        rx_line = 1'b1;
        wait_clk(4);
        check_eq("R10 break released", brk_det, 0);
        pulse_read();
        pulse_clear();
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_basic_x16();
        t_short_char();
        t_parity_x64();
        t_parity_error();
        t_framing();
        t_overrun();
        t_glitch();
        t_disabled();
        t_break();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait_clk(WATCHDOG);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule